// File: doc/BRIEF.md
# Dimmable Six-Digit Display Scanner

This block drives a six-digit multiplexed seven-segment LED display, one digit at a time. A two-stage divider turns the 4 MHz system clock into a 1 kHz slot tick (divide by 16, then by 250). Each tick moves the scanner to the next digit, in the fixed order 0 to 5, then back to 0. The first clock of every slot is dark on all lines, so the old segment pattern never shows on the new digit.

When dimming is on, the block pulses a discharge output at the start of each slot. It then keeps the digit dark until an external RC timing circuit reports that its capacitor has charged. In bright light the capacitor charges quickly, so the digit lights early and stays lit for most of the slot. In the dark it charges slowly, so the lit fraction shrinks. If the charge is not reported before the slot ends, the digit stays dark for that slot. When dimming is off, no discharge pulse is sent and the digit is lit for the whole slot except the dark first clock.

Top module: `scan_mux_dimmer`

## Requirements
- R1: `dig_en` never has more than one bit set. Slot k (counting from 0 after reset) belongs to digit k mod 6, so only bit (k mod 6) of `dig_en` can be high in that slot. The order runs 0 to 5 and then wraps to 0.
- R2: One slot lasts PRE_DIV × SLOT_DIV system clocks (16 × 250 by default, i.e. 1 ms at 4 MHz). While dimming is on, consecutive discharge pulses start exactly one slot apart.
- R3: In the first clock of every slot, `seg_out`, `dig_en` and `chg_dump` are all low.
- R4: With dimming on, `chg_dump` is high for exactly DUMP_CYC clocks, starting at the second clock of the slot. While it is high, `dig_en` is zero.
- R5: With dimming on, the digit lights three clocks after the slot's first rising edge of `chg_sense` that comes after the discharge pulse (two synchronizer flops plus the phase register). It then stays lit until the slot ends. If `chg_sense` is already high during the pulse, the digit lights on the second clock after the pulse.
- R6: With dimming on, if the charge is not seen in time to light the digit before the slot ends, the digit stays dark for the whole slot. The next slot still starts on schedule with the next digit.
- R7: With dimming off, `chg_dump` stays low and `chg_sense` has no effect. The digit is lit from the second clock of its slot through the last clock.
- R8: `clock_mode` is sampled only in the first clock of each slot (1 = dimming on). A change in the middle of a slot takes effect in the next slot.
- R9: When a digit is enabled, `seg_out` equals that digit's pattern field, `seg_pat[i*SEG_W +: SEG_W]` for digit i. When no digit is enabled, `seg_out` is zero.
- R10: Asserting `rst_n` low at once forces all outputs low, resets the scanner to digit 0 and clears the divider. Release passes through a two-flop synchronizer, so the first counting edge is the third rising clock after `rst_n` goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (4 MHz by default) |
| rst_n | input | 1 | Asynchronous active-low reset |
| seg_pat | input | DIGITS*SEG_W | Segment patterns, one SEG_W field per digit, digit 0 in the low field |
| clock_mode | input | 1 | 1 = dimming on, 0 = full brightness |
| chg_sense | input | 1 | High once the external timing capacitor is charged |
| seg_out | output | SEG_W | Segment drive of the enabled digit |
| dig_en | output | DIGITS | One-hot digit enable |
| chg_dump | output | 1 | Capacitor discharge strobe |

## Verification
The scanner is run through several slot cycles, long enough to wrap the digit order twice, under seven input patterns, and every output is compared on every clock:
- Dimming off, with `chg_sense` toggling freely: shows that the sense input has no effect.
- Sense held high: gives the earliest possible lighting point.
- Sense rising right after the pulse, and well into the slot: check the three-clock synchronizer delay and the shortened duty.
- Sense rising just early enough to light only the last clock of the slot, and one clock too late: separate the last-moment case from the dark-slot case.
- Mode flipped in the middle of a slot: shows that the new setting waits for the next slot boundary.

// File: rtl/scan_pkg.sv
package scan_pkg;

  // Phase of the current digit slot
  typedef enum logic [1:0] {
    PH_GAP  = 2'd0,  // first clock of a slot: everything dark
    PH_DUMP = 2'd1,  // discharge strobe active, digit dark
    PH_WAIT = 2'd2,  // waiting for the capacitor to report charged
    PH_LIT  = 2'd3   // digit shown for the rest of the slot
  } phase_e;

endpackage

// File: rtl/scan_rst_sync.sv
module scan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_sn = out_q;

endmodule

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
  parameter int PRE_DIV  = 16,
  parameter int SLOT_DIV = 250
) (
  input  logic clk,
  input  logic rst_sn,
  output logic slot_tick
);

  localparam int PRE_W  = $clog2(PRE_DIV);
  localparam int SLOT_W = $clog2(SLOT_DIV);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(PRE_DIV - 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_DIV - 1);

  logic [PRE_W-1:0]  pre_q, pre_n;
  logic [SLOT_W-1:0] div_q, div_n;
  logic              pre_wrap;
  logic              div_en;

  assign pre_wrap  = (pre_q == PRE_LAST);
  assign div_en    = pre_wrap;
  assign slot_tick = pre_wrap && (div_q == SLOT_LAST);

  always_comb begin
    pre_n = pre_wrap ? '0 : pre_q + 1'b1;
    div_n = div_q;
    if (div_en) begin
      div_n = (div_q == SLOT_LAST) ? '0 : div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_n;
      div_q <= div_n;
    end
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_sn)
    slot_tick |=> !slot_tick) else $error("tick repeated"); // R2

endmodule

// File: rtl/scan_sense_sync.sv
module scan_sense_sync (
  input  logic clk,
  input  logic rst_sn,
  input  logic sense_raw,
  output logic sense_s
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= sense_raw;
      sync_q <= meta_q;
    end
  end

  assign sense_s = sync_q;

endmodule

// File: rtl/scan_slot_fsm.sv
module scan_slot_fsm
  import scan_pkg::*;
#(
  parameter int DIGITS   = 6,
  parameter int DUMP_CYC = 16,
  localparam int DIG_W   = $clog2(DIGITS)
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             slot_tick,
  input  logic             dim_mode,
  input  logic             sense_s,
  output logic [DIG_W-1:0] dig_idx,
  output logic             lit_o,
  output logic             dump_o
);

  localparam int DUMP_W = $clog2(DUMP_CYC);
  localparam logic [DIG_W-1:0]  DIG_LAST  = DIG_W'(DIGITS - 1);
  localparam logic [DUMP_W-1:0] DUMP_LAST = DUMP_W'(DUMP_CYC - 1);

  phase_e            ph_q, ph_n;
  logic [DIG_W-1:0]  dig_q, dig_n;
  logic [DUMP_W-1:0] cnt_q, cnt_n;
  logic              dim_q, dim_n;

  always_comb begin
    ph_n  = ph_q;
    dig_n = dig_q;
    cnt_n = cnt_q;
    dim_n = dim_q;
    if (slot_tick) begin
      ph_n  = PH_GAP;
      dig_n = (dig_q == DIG_LAST) ? '0 : dig_q + 1'b1;
      cnt_n = '0;
    end else begin
      unique case (ph_q)
        PH_GAP: begin
          dim_n = dim_mode;
          cnt_n = '0;
          ph_n  = dim_mode ? PH_DUMP : PH_LIT;
        end
        PH_DUMP: begin
          if (cnt_q == DUMP_LAST) ph_n = PH_WAIT;
          else                    cnt_n = cnt_q + 1'b1;
        end
        PH_WAIT: begin
          if (sense_s) ph_n = PH_LIT;
        end
        PH_LIT: ph_n = PH_LIT;
        default: ph_n = PH_GAP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ph_q  <= PH_GAP;
      dig_q <= '0;
      cnt_q <= '0;
      dim_q <= 1'b0;
    end else begin
      ph_q  <= ph_n;
      dig_q <= dig_n;
      cnt_q <= cnt_n;
      dim_q <= dim_n;
    end
  end

  assign dig_idx = dig_q;
  assign lit_o   = (ph_q == PH_LIT);
  assign dump_o  = (ph_q == PH_DUMP);

  AST_GAP_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_sn)
    slot_tick |=> (!lit_o && !dump_o)) else $error("no dark gap"); // R3
  AST_DIGIT_WRAP: assert property (@(posedge clk) disable iff (!rst_sn)
    (slot_tick && dig_q == DIG_LAST) |=> (dig_q == '0)) else $error("bad wrap"); // R1
  AST_DARK_IN_DUMP: assert property (@(posedge clk) disable iff (!rst_sn)
    dump_o |-> !lit_o) else $error("lit during discharge"); // R4
  AST_NO_DUMP_BRIGHT: assert property (@(posedge clk) disable iff (!rst_sn)
    !dim_q |-> !dump_o) else $error("discharge while not dimming"); // R7
  AST_LIT_NEEDS_SENSE: assert property (@(posedge clk) disable iff (!rst_sn)
    (dim_q && $rose(lit_o)) |-> $past(sense_s)) else $error("lit without charge"); // R5

endmodule

// File: rtl/scan_mux_dimmer.sv
module scan_mux_dimmer #(
  parameter int DIGITS   = 6,
  parameter int SEG_W    = 7,
  parameter int PRE_DIV  = 16,
  parameter int SLOT_DIV = 250,
  parameter int DUMP_CYC = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [DIGITS*SEG_W-1:0] seg_pat,
  input  logic                    clock_mode,
  input  logic                    chg_sense,
  output logic [SEG_W-1:0]        seg_out,
  output logic [DIGITS-1:0]       dig_en,
  output logic                    chg_dump
);

  localparam int DIG_W = $clog2(DIGITS);

  logic             rst_sn;
  logic             slot_tick;
  logic             sense_s;
  logic [DIG_W-1:0] dig_idx;
  logic             lit;
  logic [SEG_W-1:0] seg_sel;

  scan_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  scan_tick_gen #(
    .PRE_DIV  (PRE_DIV),
    .SLOT_DIV (SLOT_DIV)
  ) u_tick (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .slot_tick (slot_tick)
  );

  scan_sense_sync u_sense (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .sense_raw (chg_sense),
    .sense_s   (sense_s)
  );

  scan_slot_fsm #(
    .DIGITS   (DIGITS),
    .DUMP_CYC (DUMP_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_sn    (rst_sn),
    .slot_tick (slot_tick),
    .dim_mode  (clock_mode),
    .sense_s   (sense_s),
    .dig_idx   (dig_idx),
    .lit_o     (lit),
    .dump_o    (chg_dump)
  );

  always_comb begin
    seg_sel = '0;
    for (int i = 0; i < DIGITS; i++) begin
      if (dig_idx == DIG_W'(i)) seg_sel = seg_pat[i*SEG_W +: SEG_W];
    end
  end

  genvar g;
  generate
    for (g = 0; g < DIGITS; g++) begin : g_en
      assign dig_en[g] = lit && (dig_idx == DIG_W'(g));
    end
  endgenerate

  assign seg_out = lit ? seg_sel : '0;

  AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(dig_en)) else $error("several digits on"); // R1
  AST_SEG_DARK: assert property (@(posedge clk) disable iff (!rst_sn)
    (dig_en == '0) |-> (seg_out == '0)) else $error("segments without digit"); // R9

endmodule

// File: tb/scan_mux_dimmer_test.sv
module scan_mux_dimmer_test;

  localparam int DIGITS   = 6;
  localparam int SEG_W    = 7;
  localparam int PRE_DIV  = 4;
  localparam int SLOT_DIV = 10;
  localparam int DUMP_CYC = 4;
  localparam int SLOT     = PRE_DIV * SLOT_DIV;
  localparam int NSLOTS   = 13;

  logic                    clk = 1'b0;
  logic                    rst_n;
  logic [DIGITS*SEG_W-1:0] seg_pat;
  logic                    clock_mode;
  logic                    chg_sense;
  logic [SEG_W-1:0]        seg_out;
  logic [DIGITS-1:0]       dig_en;
  logic                    chg_dump;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  scan_mux_dimmer #(
    .DIGITS   (DIGITS),
    .SEG_W    (SEG_W),
    .PRE_DIV  (PRE_DIV),
    .SLOT_DIV (SLOT_DIV),
    .DUMP_CYC (DUMP_CYC)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .seg_pat    (seg_pat),
    .clock_mode (clock_mode),
    .chg_sense  (chg_sense),
    .seg_out    (seg_out),
    .dig_en     (dig_en),
    .chg_dump   (chg_dump)
  );

  function automatic logic [SEG_W-1:0] pat_of(int i);
    return SEG_W'((i * 37 + 5) % 128);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // kind: 0 sense held high, 1 sense rises dly clocks after pulse, 2 sense toggles
  task automatic run_case(input logic start_mode, input int kind, input int dly,
                          input int toggle_at, input string base_tag);
    logic eff_mode;
    int   last_rise;
    logic prev_dump;
    rst_n      = 1'b0;
    clock_mode = start_mode;
    chg_sense  = (kind == 0);
    repeat (3) @(negedge clk);
    chk("R10", "dig_en in reset", int'(dig_en), 0);
    chk("R10", "seg_out in reset", int'(seg_out), 0);
    chk("R10", "chg_dump in reset", int'(chg_dump), 0);
    rst_n     = 1'b1;
    eff_mode  = start_mode;
    last_rise = -1;
    prev_dump = 1'b0;
    for (int n = 1; n <= 2 + NSLOTS * SLOT; n++) begin
      int    m, k, p, dg, lit_start;
      logic  exp_lit, exp_dump;
      string tag;
      @(negedge clk);
      m  = (n < 2) ? 0 : n - 2;
      k  = m / SLOT;
      p  = m % SLOT;
      dg = k % DIGITS;
      if (!eff_mode)      lit_start = 1;
      else if (kind == 0) lit_start = DUMP_CYC + 2;
      else                lit_start = DUMP_CYC + 1 + dly + 3;
      exp_lit  = (p >= 1) && (p >= lit_start);
      exp_dump = eff_mode && (p >= 1) && (p <= DUMP_CYC);
      if (n <= 2)                         tag = "R10";
      else if (p == 0)                    tag = "R3";
      else if (toggle_at >= 0)            tag = "R8";
      else if (!eff_mode)                 tag = "R7";
      else if (p <= DUMP_CYC)             tag = "R4";
      else if (lit_start >= SLOT)         tag = "R6";
      else                                tag = base_tag;
      chk(tag, "dig_en", int'(dig_en), exp_lit ? (1 << dg) : 0);
      chk(exp_lit ? "R9" : tag, "seg_out", int'(seg_out), exp_lit ? int'(pat_of(dg)) : 0);
      chk(tag, "chg_dump", int'(chg_dump), int'(exp_dump));
      if (exp_lit) chk("R1", "digit index", int'(dig_en), 1 << (k % DIGITS));
      if (chg_dump && !prev_dump) begin
        if (last_rise >= 0) chk("R2", "pulse spacing", m - last_rise, SLOT);
        last_rise = m;
      end
      prev_dump = chg_dump;
      // drive inputs for the next edge
      if (toggle_at >= 0 && k == 1 && p == toggle_at) clock_mode = ~clock_mode;
      if (p == 0) eff_mode = clock_mode;
      if (kind == 0)      chg_sense = 1'b1;
      else if (kind == 1) chg_sense = (p >= DUMP_CYC + 1 + dly);
      else                chg_sense = ((n * 5) % 7) < 3;
    end
  endtask

  initial begin
    for (int i = 0; i < DIGITS; i++) seg_pat[i*SEG_W +: SEG_W] = pat_of(i);
    rst_n      = 1'b0;
    clock_mode = 1'b0;
    chg_sense  = 1'b0;
    run_case(1'b0, 2, 0,  -1, "R7");  // bright mode, sense toggling
    run_case(1'b1, 0, 0,  -1, "R5");  // sense held high
    run_case(1'b1, 1, 0,  -1, "R5");  // charges right after pulse
    run_case(1'b1, 1, 12, -1, "R5");  // mid-slot charge
    run_case(1'b1, 1, 31, -1, "R5");  // lit in last clock only
    run_case(1'b1, 1, 32, -1, "R6");  // one clock too late: dark slot
    run_case(1'b1, 1, 3,  20, "R8");  // mode change mid-slot
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule